// File: doc/BRIEF.md
# Alternating I/Q Word Serializer

This block drains 32-bit words from the read side of a FIFO and sends each one out one bit per clock, least significant bit first. Successive words are steered to two serial pins in turn: the first word after reset goes to the I pin, the next to the Q pin, and so on. The pin that is not carrying a word stays at logic 0, and both pins rest at 0 when no word is in flight.

The FIFO is consulted only when the block has nothing to send. In that case, if the FIFO reports data, the block raises a single-cycle read request. It then captures the word one cycle later, which matches a FIFO with one cycle of read latency. From then on it shifts all 32 bits regardless of what the empty flag does. A busy output marks the 32 cycles in which bits are being presented.

Top module: `iqs_serializer`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `fifo_rd_en`, `busy`, `ser_i` and `ser_q` are 0, even if `fifo_empty` is low.
- R2: `fifo_rd_en` is asserted in exactly those cycles where the block is idle (busy low and no fetch outstanding) and `fifo_empty` is low, and it never stays high two cycles in a row.
- R3: The word on `fifo_data` is taken in the cycle right after the `fifo_rd_en` cycle, and `busy` rises in the cycle after that. The value of `fifo_data` in every other cycle has no effect on the pins.
- R4: Bit 0 of the word appears on its pin in the first cycle with `busy` high, and bit k appears k cycles later (LSB first, one bit per cycle).
- R5: Words alternate between pins. Word 0 after reset goes to `ser_i`, word 1 to `ser_q`, word 2 to `ser_i`, and so on.
- R6: The pin not carrying the current word reads 0, and both pins read 0 whenever `busy` is low.
- R7: For each word, `busy` stays high for exactly 32 consecutive cycles.
- R8: Changes of `fifo_empty` between the read request and the last bit have no effect, and the word always completes.
- R9: No read request is issued while `busy` is high or while a fetched word is still awaited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_data | input | 32 | FIFO read data, valid one cycle after a request |
| fifo_rd_en | output | 1 | Single-cycle read request to the FIFO |
| ser_i | output | 1 | Serial pin for even-numbered words |
| ser_q | output | 1 | Serial pin for odd-numbered words |
| busy | output | 1 | High while the 32 bits of a word are presented |

## Verification
Two events can fall in the same cycle: the final bit of one word finishes, and the FIFO has data waiting. When that happens, the read request must come in the very first idle cycle, and the next word must switch to the other pin. The bench builds a backlog of released words so that these back-to-back fetches happen. It checks that each `fifo_rd_en` lands exactly where the idle rule predicts and that the pin choice follows word parity. It also toggles `fifo_empty` at random while words are in flight, feeds garbage on `fifo_data` outside the capture cycle, and requires every word to arrive intact.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

    typedef enum logic [1:0] {
        FETCH_IDLE = 2'd0,
        FETCH_WAIT = 2'd1,
        FETCH_RUN  = 2'd2
    } fetch_state_e;

    typedef struct packed {
        fetch_state_e state;
    } fetch_regs_t;

    typedef struct packed {
        logic sel;
    } steer_regs_t;

endpackage

// File: rtl/iqs_fetch_ctrl.sv
module iqs_fetch_ctrl
    import iqs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fifo_empty,
    input  logic shift_last,
    output logic rd_en,
    output logic load
);

    fetch_regs_t fr_d, fr_q;

    // Next-state and strobe logic
    always_comb begin
        fr_d  = fr_q;
        rd_en = 1'b0;
        load  = 1'b0;
        case (fr_q.state)
            FETCH_IDLE: begin
                if (!fifo_empty && !rst) begin
                    rd_en      = 1'b1;
                    fr_d.state = FETCH_WAIT;
                end
            end
            FETCH_WAIT: begin
                load       = 1'b1;
                fr_d.state = FETCH_RUN;
            end
            FETCH_RUN: begin
                if (shift_last) begin
                    fr_d.state = FETCH_IDLE;
                end
            end
            default: fr_d.state = FETCH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q.state <= FETCH_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

endmodule

// File: rtl/iqs_shifter.sv
module iqs_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out,
    output logic              active,
    output logic              last
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              bitv;
        logic              act;
    } shift_regs_t;

    shift_regs_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d.sh   = word >> 1;
            sr_d.bitv = word[0];
            sr_d.cnt  = CNT_W'(1);
            sr_d.act  = 1'b1;
        end else if (sr_q.act) begin
            if (sr_q.cnt == LAST_CNT) begin
                sr_d.act  = 1'b0;
                sr_d.bitv = 1'b0;
                sr_d.cnt  = '0;
                sr_d.sh   = '0;
            end else begin
                sr_d.bitv = sr_q.sh[0];
                sr_d.sh   = sr_q.sh >> 1;
                sr_d.cnt  = sr_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign bit_out = sr_q.bitv;
    assign active  = sr_q.act;
    assign last    = sr_q.act && (sr_q.cnt == LAST_CNT);

endmodule

// File: rtl/iqs_lane_steer.sv
module iqs_lane_steer
    import iqs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic last,
    input  logic bit_in,
    output logic ser_i,
    output logic ser_q
);

    steer_regs_t st_d, st_q;

    // Flip the lane after each finished word
    always_comb begin
        st_d     = st_q;
        st_d.sel = st_q.sel ^ last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sel <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_i = active && !st_q.sel && bit_in;
    assign ser_q = active &&  st_q.sel && bit_in;

endmodule

// File: rtl/iqs_serializer.sv
module iqs_serializer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_rd_en,
    output logic              ser_i,
    output logic              ser_q,
    output logic              busy
);

    logic load_w;
    logic bit_w;
    logic active_w;
    logic last_w;

    iqs_fetch_ctrl u_fetch (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .shift_last (last_w),
        .rd_en      (fifo_rd_en),
        .load       (load_w)
    );

    iqs_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load_w),
        .word    (fifo_data),
        .bit_out (bit_w),
        .active  (active_w),
        .last    (last_w)
    );

    iqs_lane_steer u_steer (
        .clk    (clk),
        .rst    (rst),
        .active (active_w),
        .last   (last_w),
        .bit_in (bit_w),
        .ser_i  (ser_i),
        .ser_q  (ser_q)
    );

    assign busy = active_w;

endmodule

// File: rtl/iqs_serializer_chk.sv
module iqs_serializer_chk #(
    parameter int WORD_W = 32
) (
    input logic clk,
    input logic rst,
    input logic fifo_empty,
    input logic fifo_rd_en,
    input logic ser_i,
    input logic ser_q,
    input logic busy
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + CNT_W'(1);
        end else begin
            run_cnt <= '0;
        end
    end

    // R2
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> !fifo_rd_en);

    // R2
    rd_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> !fifo_empty);

    // R9
    rd_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !fifo_rd_en);

    // R3
    load_gap_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> !busy);

    // R3
    busy_follows_chk: assert property (@(posedge clk) disable iff (rst)
        $past(fifo_rd_en, 2) |-> busy);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_i && !ser_q));

    // R6
    one_lane_chk: assert property (@(posedge clk) disable iff (rst)
        !(ser_i && ser_q));

    // R7
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == CNT_W'(WORD_W)));

    // R7
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < CNT_W'(WORD_W)));

endmodule

bind iqs_serializer iqs_serializer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .fifo_rd_en (fifo_rd_en),
    .ser_i      (ser_i),
    .ser_q      (ser_q),
    .busy       (busy)
);

// File: tb/sim_iqs_serializer.sv
module sim_iqs_serializer;

    localparam int NW   = 40;
    localparam int MAXC = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_data = '0;
    logic        fifo_rd_en, ser_i, ser_q, busy;

    int checks = 0;
    int errors = 0;
    logic [31:0] words [NW];

    iqs_serializer u0 (
        .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd_en(fifo_rd_en), .ser_i(ser_i), .ser_q(ser_q), .busy(busy)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] gen_word(input int i);
        case (i)
            0: return 32'h0000_0001;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'hA5A5_3C0F;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic exp_rd(input logic b, input logic pend, input logic emp);
        return !b && !pend && !emp;
    endfunction

    function automatic logic lane_is_q(input int k);
        return (k % 2) == 1;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        int rd_idx = 0, released = 0, word_cnt = 0, bitpos = 0, rd_cyc = -10, cyc = 0;
        logic pending = 0, hold = 0, prev_busy = 0, empty_seen = 0, blk;
        logic [31:0] cur_word = '0, got = '0;
        logic pa, pb;

        void'($urandom(32'd4242));
        for (int i = 0; i < NW; i++) words[i] = gen_word(i);

        // R1: reset with data offered
        fifo_empty = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!fifo_rd_en && !busy && !ser_i && !ser_q, "R1 reset outputs",
                  {28'd0, fifo_rd_en, busy, ser_i, ser_q}, 32'd0);
        end
        fifo_empty = 1'b1;
        rst = 1'b0;

        while (word_cnt < NW && cyc < MAXC) begin
            @(negedge clk);
            cyc++;
            if (cyc == 20) released = 1;
            else if (cyc == 150) released = 4;
            else if (cyc > 150 && released < NW && ($urandom % 12 == 0)) released++;
            blk = ($urandom % 4 == 0) && (cyc > 60);
            fifo_empty = (rd_idx >= released) || blk;
            #1;

            if (busy && !prev_busy) begin
                check(cyc == rd_cyc + 2, "R3 busy rise timing", cyc, rd_cyc + 2);
                bitpos = 0; got = '0; pending = 0;
            end
            if (busy) begin
                pa = lane_is_q(word_cnt) ? ser_q : ser_i;
                pb = lane_is_q(word_cnt) ? ser_i : ser_q;
                if (bitpos < 32) got[bitpos] = pa;
                check(pb == 1'b0, "R6 idle lane low", {31'd0, pb}, 32'd0);
                bitpos++;
            end else begin
                check(!ser_i && !ser_q, "R6 pins low when not busy", {30'd0, ser_i, ser_q}, 32'd0);
            end
            if (!busy && prev_busy) begin
                check(bitpos == 32, "R7 busy length", bitpos, 32);
                check(got == cur_word, "R4 R5 word order and lane", got, cur_word);
                if (empty_seen)
                    check(got == cur_word, "R8 word completed despite empty", got, cur_word);
                word_cnt++;
                empty_seen = 0;
            end

            // R2 / R9: request only when idle with data
            check(fifo_rd_en == exp_rd(busy, pending, fifo_empty), "R2 R9 read request",
                  {31'd0, fifo_rd_en}, {31'd0, exp_rd(busy, pending, fifo_empty)});
            if ((busy || pending) && fifo_empty) empty_seen = 1;

            if (hold) begin
                hold = 0;
            end else if (fifo_rd_en) begin
                cur_word = words[rd_idx];
                fifo_data = cur_word;
                rd_idx++;
                hold = 1;
                pending = 1;
                rd_cyc = cyc;
            end else begin
                fifo_data = $urandom;   // R3: garbage outside capture cycle
            end
            prev_busy = busy;
        end

        if (word_cnt < NW) begin
            checks++;
            errors++;
            $display("FAIL watchdog words %0d expected %0d", word_cnt, NW);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule